// File: doc/BRIEF.md
# Audio DMA Stream Control Sequencer

This block holds the control state of one audio DMA stream. Software writes a three-bit control word that carries a stream reset request, a run request and a completion-interrupt enable. The block turns these into a run enable for the DMA engine, a reset line for the stream's descriptor registers and FIFO, and a one-cycle reset pulse for an output stream's cadence generator. The engine tells the block through a level input whether it has truly come to a halt.

The run and reset bits read back the real hardware state, not the last value written. A cleared run bit keeps reading 1 until the engine has halted. Entering and leaving reset each take a parameterised number of cycles before the reset readback changes. While the stream is in reset or sequencing, writes to the stream's other registers are blocked and flagged. A request for reset while the stream is still running is recorded as a protocol error, and the reset waits until the engine halts. Buffer-completion events set a sticky status bit, and the interrupt follows that bit and the enable.

The block has no data path, so there is no valid/ready interface. All pins are plain control and status levels or strobes.

Top module: `dma_stream_ctl`

## Requirements
- R1: The control word has the reset request at bit 0, the run request at bit 1 and the interrupt enable at bit 2. `reg_rdata` uses the same bit positions.
- R2: `dma_run` is 1 only when the stored run bit is 1, `ssync` is 0 and the reset sequencer is idle.
- R3: After the run bit is written to 0, readback bit 1 stays 1 as long as `eng_stopped` is 0. It reads 0 once `eng_stopped` is 1 and the stored run bit is 0.
- R4: `buf_done` sets status bit 2 whatever the enable holds. Writing 1 to status bit 2 clears it, and a completion in the same cycle wins over the clear. `irq` is 1 exactly when status bit 2 and the enable are both 1.
- R5: With IS_OUTPUT=1, an accepted control write that sets the run bit makes `cad_rst` high for exactly the one cycle after the write.
- R6: An accepted reset request raises `strm_rst` in the cycle after the write and clears the run bit, the enable and status bit 2. Readback bit 0 stays 0 until ENTER_CYC cycles after the write edge, then reads 1.
- R7: Writing 0 to the reset bit while the stream is held drops `strm_rst` in the next cycle. Readback bit 0 stays 1 until EXIT_CYC cycles after the write edge, then reads 0.
- R8: A reset request made while readback bit 1 is 1 sets status bit 0, the protocol-error flag. `strm_rst` then stays 0 until `eng_stopped` is seen as 1. ENTER_CYC more cycles then pass before readback bit 0 reads 1.
- R9: While the sequencer is not idle, `other_wr_en` is 0, an `other_wr` strobe sets status bit 1 (the access-error flag), and control writes leave the run and enable bits unchanged.
- R10: Status bits 0 and 1 are sticky. Writing 1 to either one clears it, and a stream reset does not clear them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 3 | Control word write data |
| reg_rdata | output | 3 | Control word readback (hardware state) |
| sts_wr | input | 1 | Status write strobe (write 1 to clear) |
| sts_wdata | input | 3 | Status write data |
| sts_rdata | output | 3 | Status: bit 0 protocol error, bit 1 access error, bit 2 buffer complete |
| other_wr | input | 1 | Write strobe aimed at the stream's other registers |
| other_wr_en | output | 1 | Passes `other_wr` on when the stream is idle |
| ssync | input | 1 | Stream synchronisation hold; 1 blocks the engine |
| eng_stopped | input | 1 | Engine reports it is fully halted |
| buf_done | input | 1 | Buffer completed with its completion-interrupt flag set |
| dma_run | output | 1 | Run enable to the DMA engine |
| strm_rst | output | 1 | Reset to the stream descriptors and FIFO |
| cad_rst | output | 1 | Cadence generator reset pulse |
| irq | output | 1 | Stream interrupt |

## Verification
The bench builds the block with ENTER_CYC=3, EXIT_CYC=5 and IS_OUTPUT=1. These short sequencing windows let every cycle of both reset transitions be sampled and compared against its own count. Because they differ, a swap of the two counts shows up. The output variant brings the cadence pulse within reach, and a long random phase of completions, clears and enable toggles runs against a bench model of the status and interrupt.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic [2:0] {
    RS_IDLE  = 3'd0,
    RS_PEND  = 3'd1,
    RS_ENTER = 3'd2,
    RS_HELD  = 3'd3,
    RS_EXIT  = 3'd4
  } rst_state_e;

  localparam int CTL_RST   = 0;
  localparam int CTL_RUN   = 1;
  localparam int CTL_IOC   = 2;
  localparam int STS_PROTO = 0;
  localparam int STS_ACC   = 1;
  localparam int STS_BUF   = 2;
  localparam int CTL_W     = 3;
endpackage

// File: rtl/dsc_rst_seq.sv
module dsc_rst_seq
  import dsc_pkg::*;
#(
  parameter int ENTER_CYC = 4,
  parameter int EXIT_CYC  = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  input  logic run_busy,
  input  logic eng_stopped,
  output logic busy,
  output logic rst_rb,
  output logic strm_rst,
  output logic proto_evt,
  output logic desc_clr
);
  localparam int MAXC = (ENTER_CYC > EXIT_CYC) ? ENTER_CYC : EXIT_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] ENT_L = CW'(ENTER_CYC);
  localparam logic [CW-1:0] EXT_L = CW'(EXIT_CYC);
  localparam logic [CW-1:0] ONE   = CW'(1);

  rst_state_e      state, state_n;
  logic [CW-1:0]   cnt, cnt_n;

  assign busy      = (state != RS_IDLE);
  assign rst_rb    = (state == RS_HELD) || (state == RS_EXIT);
  assign strm_rst  = (state == RS_ENTER) || (state == RS_HELD);
  assign desc_clr  = set_req && (state == RS_IDLE);
  assign proto_evt = desc_clr && run_busy;

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    case (state)
      RS_IDLE: if (set_req) begin
        if (run_busy) state_n = RS_PEND;
        else begin
          state_n = RS_ENTER;
          cnt_n   = ENT_L;
        end
      end
      RS_PEND: if (eng_stopped) begin
        state_n = RS_ENTER;
        cnt_n   = ENT_L;
      end
      RS_ENTER: begin
        if (cnt == ONE) state_n = RS_HELD;
        else cnt_n = cnt - ONE;
      end
      RS_HELD: if (clr_req) begin
        state_n = RS_EXIT;
        cnt_n   = EXT_L;
      end
      RS_EXIT: begin
        if (cnt == ONE) state_n = RS_IDLE;
        else cnt_n = cnt - ONE;
      end
      default: state_n = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RS_IDLE;
      cnt   <= '0;
    end else begin
      state <= state_n;
      cnt   <= cnt_n;
    end
  end

  // R6: the held state is reached only when the entry count runs out
  p_enter_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_rb) |-> ($past(state) == RS_ENTER && $past(cnt) == ONE));
  // R7: the reset readback drops only at the end of the exit count
  p_exit_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_rb) |-> ($past(state) == RS_EXIT && $past(cnt) == ONE));
  // R8: leaving the pending state needs the engine to be halted
  p_pend_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == RS_PEND && state == RS_ENTER) |-> $past(eng_stopped));
endmodule

// File: rtl/dsc_run_ctl.sv
module dsc_run_ctl
  import dsc_pkg::*;
#(
  parameter bit IS_OUTPUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ok,
  input  logic [CTL_W-1:0]  wdata,
  input  logic              desc_clr,
  input  logic              busy,
  input  logic              ssync,
  output logic              run_sw,
  output logic              ioc_en,
  output logic              dma_run,
  output logic              cad_rst
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_sw <= 1'b0;
      ioc_en <= 1'b0;
    end else if (desc_clr) begin
      run_sw <= 1'b0;
      ioc_en <= 1'b0;
    end else if (wr_ok) begin
      run_sw <= wdata[CTL_RUN];
      ioc_en <= wdata[CTL_IOC];
    end
  end

  assign dma_run = run_sw && !ssync && !busy;

  generate
    if (IS_OUTPUT) begin : g_cad
      logic cad_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cad_q <= 1'b0;
        else        cad_q <= wr_ok && wdata[CTL_RUN];
      end
      assign cad_rst = cad_q;
      // R5: a cadence pulse always follows a write that left run set
      p_cad_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cad_rst |-> (run_sw && $past(wr_ok)));
    end else begin : g_nocad
      assign cad_rst = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/dsc_irq_stat.sv
module dsc_irq_stat
  import dsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              buf_done,
  input  logic              sts_wr,
  input  logic [CTL_W-1:0]  sts_wdata,
  input  logic              desc_clr,
  input  logic              proto_evt,
  input  logic              acc_evt,
  input  logic              ioc_en,
  output logic [CTL_W-1:0]  sts,
  output logic              irq
);
  logic bcis, perr, aerr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcis <= 1'b0;
      perr <= 1'b0;
      aerr <= 1'b0;
    end else begin
      if (desc_clr)                              bcis <= 1'b0;
      else if (buf_done)                         bcis <= 1'b1;
      else if (sts_wr && sts_wdata[STS_BUF])     bcis <= 1'b0;

      if (proto_evt)                             perr <= 1'b1;
      else if (sts_wr && sts_wdata[STS_PROTO])   perr <= 1'b0;

      if (acc_evt)                               aerr <= 1'b1;
      else if (sts_wr && sts_wdata[STS_ACC])     aerr <= 1'b0;
    end
  end

  always_comb begin
    sts            = '0;
    sts[STS_BUF]   = bcis;
    sts[STS_PROTO] = perr;
    sts[STS_ACC]   = aerr;
  end
  assign irq = bcis && ioc_en;

  // R4: completion status appears only after a completion event
  p_buf_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bcis) |-> $past(buf_done));
  // R10: error flags only clear through a status write
  p_flag_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(perr) |-> $past(sts_wr));
endmodule

// File: rtl/dma_stream_ctl.sv
module dma_stream_ctl
  import dsc_pkg::*;
#(
  parameter int ENTER_CYC = 4,
  parameter int EXIT_CYC  = 6,
  parameter bit IS_OUTPUT = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [2:0] reg_wdata,
  output logic [2:0] reg_rdata,
  input  logic       sts_wr,
  input  logic [2:0] sts_wdata,
  output logic [2:0] sts_rdata,
  input  logic       other_wr,
  output logic       other_wr_en,
  input  logic       ssync,
  input  logic       eng_stopped,
  input  logic       buf_done,
  output logic       dma_run,
  output logic       strm_rst,
  output logic       cad_rst,
  output logic       irq
);
  logic busy, rst_rb, proto_evt, desc_clr;
  logic run_sw, ioc_en, run_rb, wr_ok, acc_evt;

  assign run_rb  = run_sw || !eng_stopped;
  assign wr_ok   = reg_wr && !busy && !reg_wdata[CTL_RST];
  assign acc_evt = other_wr && busy;
  assign other_wr_en = other_wr && !busy;

  dsc_rst_seq #(.ENTER_CYC(ENTER_CYC), .EXIT_CYC(EXIT_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .set_req(reg_wr && reg_wdata[CTL_RST]),
    .clr_req(reg_wr && !reg_wdata[CTL_RST]),
    .run_busy(run_rb), .eng_stopped(eng_stopped),
    .busy(busy), .rst_rb(rst_rb), .strm_rst(strm_rst),
    .proto_evt(proto_evt), .desc_clr(desc_clr)
  );

  dsc_run_ctl #(.IS_OUTPUT(IS_OUTPUT)) u_run (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .wdata(reg_wdata),
    .desc_clr(desc_clr), .busy(busy), .ssync(ssync),
    .run_sw(run_sw), .ioc_en(ioc_en), .dma_run(dma_run), .cad_rst(cad_rst)
  );

  dsc_irq_stat u_stat (
    .clk(clk), .rst_n(rst_n), .buf_done(buf_done), .sts_wr(sts_wr),
    .sts_wdata(sts_wdata), .desc_clr(desc_clr), .proto_evt(proto_evt),
    .acc_evt(acc_evt), .ioc_en(ioc_en), .sts(sts_rdata), .irq(irq)
  );

  always_comb begin
    reg_rdata          = '0;
    reg_rdata[CTL_RST] = rst_rb;
    reg_rdata[CTL_RUN] = run_rb;
    reg_rdata[CTL_IOC] = ioc_en;
  end

  // R2: the engine never runs while the stream reset is driven
  p_run_vs_rst_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dma_run |-> !strm_rst);
  // R9: a blocked access always leaves the access-error flag set
  p_block_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (other_wr && strm_rst) |=> sts_rdata[STS_ACC]);
  // R8: the protocol-error flag rises only on a control write
  p_proto_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_rdata[STS_PROTO]) |-> $past(reg_wr));
endmodule

// File: tb/tb_dma_stream_ctl.sv
module tb_dma_stream_ctl;
  localparam int ENT = 3;
  localparam int EXT = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 0, sts_wr = 0, other_wr = 0, ssync = 0, eng_stopped = 1, buf_done = 0;
  logic [2:0] reg_wdata = 0, sts_wdata = 0;
  logic [2:0] reg_rdata, sts_rdata;
  logic other_wr_en, dma_run, strm_rst, cad_rst, irq;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  dma_stream_ctl #(.ENTER_CYC(ENT), .EXIT_CYC(EXT), .IS_OUTPUT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sts_wr(sts_wr), .sts_wdata(sts_wdata),
    .sts_rdata(sts_rdata), .other_wr(other_wr), .other_wr_en(other_wr_en),
    .ssync(ssync), .eng_stopped(eng_stopped), .buf_done(buf_done),
    .dma_run(dma_run), .strm_rst(strm_rst), .cad_rst(cad_rst), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr_ctl(input logic [2:0] d);
    reg_wr = 1; reg_wdata = d; step(); reg_wr = 0;
  endtask

  task automatic wr_sts(input logic [2:0] d);
    sts_wr = 1; sts_wdata = d; step(); sts_wr = 0; sts_wdata = 0;
  endtask

  function automatic logic exp_irq(input logic b, input logic e);
    return b & e;
  endfunction

  initial begin
    #1500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic bm, im;
    void'($urandom(32'd4242));
    repeat (3) step();
    rst_n = 1; step();
    chk("R1 reset readback", {5'd0, reg_rdata}, 8'h0);
    chk("R10 reset status", {5'd0, sts_rdata}, 8'h0);
    chk("R2 reset dma_run", {7'd0, dma_run}, 8'h0);

    // R5/R2: run with cadence pulse
    wr_ctl(3'b010);
    chk("R5 cad pulse", {7'd0, cad_rst}, 8'h1);
    chk("R2 run active", {7'd0, dma_run}, 8'h1);
    chk("R1 run bit1", {5'd0, reg_rdata}, 8'h2);
    eng_stopped = 0;
    step();
    chk("R5 cad one cycle", {7'd0, cad_rst}, 8'h0);
    ssync = 1; #1;
    chk("R2 ssync blocks", {7'd0, dma_run}, 8'h0);
    ssync = 0; #1;

    // R3: stop handshake
    wr_ctl(3'b000);
    chk("R3 still running rb", {7'd0, reg_rdata[1]}, 8'h1);
    chk("R2 run off", {7'd0, dma_run}, 8'h0);
    repeat (3) step();
    chk("R3 waits engine", {7'd0, reg_rdata[1]}, 8'h1);
    eng_stopped = 1; #1;
    chk("R3 stopped rb", {7'd0, reg_rdata[1]}, 8'h0);

    // R4: status and enable
    buf_done = 1; step(); buf_done = 0;
    chk("R4 status w/o enable", {7'd0, sts_rdata[2]}, 8'h1);
    chk("R4 no irq w/o enable", {7'd0, irq}, 8'h0);
    wr_ctl(3'b100);
    chk("R4 irq with enable", {7'd0, irq}, 8'h1);
    sts_wr = 1; sts_wdata = 3'b100; buf_done = 1; step();
    sts_wr = 0; sts_wdata = 0; buf_done = 0;
    chk("R4 set wins clear", {7'd0, sts_rdata[2]}, 8'h1);

    // R6: clean reset entry (enable and status set beforehand)
    wr_ctl(3'b001);
    chk("R6 strm_rst up", {7'd0, strm_rst}, 8'h1);
    chk("R6 descriptors cleared", {5'd0, reg_rdata}, 8'h0);
    chk("R6 status cleared", {7'd0, sts_rdata[2]}, 8'h0);
    chk("R8 no proto err", {7'd0, sts_rdata[0]}, 8'h0);
    for (int i = 0; i < ENT - 1; i++) begin
      step();
      chk("R6 rb waits", {7'd0, reg_rdata[0]}, 8'h0);
    end
    step();
    chk("R6 rb set", {7'd0, reg_rdata[0]}, 8'h1);

    // R9: blocking while held
    other_wr = 1; #1;
    chk("R9 other blocked", {7'd0, other_wr_en}, 8'h0);
    step(); other_wr = 0;
    chk("R9 access flag", {7'd0, sts_rdata[1]}, 8'h1);
    wr_ctl(3'b111);
    chk("R9 ctl ignored", {5'd0, reg_rdata}, 8'h1);

    // R7: exit
    wr_ctl(3'b000);
    chk("R7 strm_rst down", {7'd0, strm_rst}, 8'h0);
    chk("R7 rb held", {7'd0, reg_rdata[0]}, 8'h1);
    for (int i = 0; i < EXT - 1; i++) begin
      step();
      chk("R7 rb waits", {7'd0, reg_rdata[0]}, 8'h1);
    end
    step();
    chk("R7 rb clear", {7'd0, reg_rdata[0]}, 8'h0);
    other_wr = 1; #1;
    chk("R9 other passes idle", {7'd0, other_wr_en}, 8'h1);
    other_wr = 0;
    chk("R10 flag survives reset", {7'd0, sts_rdata[1]}, 8'h1);
    wr_sts(3'b010);
    chk("R10 flag cleared", {5'd0, sts_rdata}, 8'h0);

    // R8: reset while running
    wr_ctl(3'b010); eng_stopped = 0; step();
    wr_ctl(3'b001);
    chk("R8 proto flag", {7'd0, sts_rdata[0]}, 8'h1);
    chk("R8 reset delayed", {7'd0, strm_rst}, 8'h0);
    chk("R8 run rb while stopping", {7'd0, reg_rdata[1]}, 8'h1);
    repeat (3) step();
    chk("R8 still delayed", {7'd0, strm_rst}, 8'h0);
    eng_stopped = 1; step();
    chk("R8 reset starts", {7'd0, strm_rst}, 8'h1);
    for (int i = 0; i < ENT - 1; i++) begin
      step();
      chk("R8 rb waits", {7'd0, reg_rdata[0]}, 8'h0);
    end
    step();
    chk("R8 rb set", {7'd0, reg_rdata[0]}, 8'h1);
    wr_ctl(3'b000);
    repeat (EXT) step();
    chk("R7 back idle", {7'd0, reg_rdata[0]}, 8'h0);
    wr_sts(3'b001);
    chk("R10 proto cleared", {7'd0, sts_rdata[0]}, 8'h0);

    // R4 random: completions, clears and enable toggles
    bm = 1'b0; im = 1'b0;
    wr_sts(3'b100);
    for (int k = 0; k < 400; k++) begin
      logic bd, cl, wc, ie;
      bd = ($urandom % 4) == 0;
      cl = ($urandom % 3) == 0;
      wc = ($urandom % 5) == 0;
      ie = $urandom % 2;
      buf_done = bd; sts_wr = cl; sts_wdata = {cl, 2'b00};
      reg_wr = wc; reg_wdata = {ie, 2'b00};
      step();
      buf_done = 0; sts_wr = 0; sts_wdata = 0; reg_wr = 0;
      if (bd) bm = 1'b1; else if (cl) bm = 1'b0;
      if (wc) im = ie;
      chk("R4 random status", {7'd0, sts_rdata[2]}, {7'd0, bm});
      chk("R1 random enable", {7'd0, reg_rdata[2]}, {7'd0, im});
      chk("R4 random irq", {7'd0, irq}, {7'd0, exp_irq(bm, im)});
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule